// File: doc/BRIEF.md
# Clock-Calendar Register File with Alarm and Update Flags

This block is the host-facing side of a clock-calendar peripheral. It has 128 bytes of register space behind a two-address port. A write to the even address chooses which byte is addressed. An access to the odd address then reads or writes that byte. The space holds four control and status registers, three alarm bytes, three captured time bytes and general-purpose storage.

The calendar arithmetic sits in a separate block. That block reports the start and the end of each one-second update with two strobes. At the end of an update it presents the new seconds, minutes and hours on three byte inputs. This block sets and clears the update-in-progress bit around those strobes. At the end of each update it copies the time bytes into storage, compares the alarm bytes against the new time, and raises the update-ended and alarm flags. Enabled flags drive the interrupt line. A host read of the flag register returns the flags, clears them and drops the interrupt. A set-mode bit in the second control register freezes all update processing while the host loads a new time.

Top module: `rtc_regfile`

## Requirements
- R1: After `rst` the registers read back as follows: index 0x0A = 0x26, index 0x0B = 0x02, index 0x0C = 0x00, index 0x0D = 0x80. Every storage byte reads 0x00, `irq` is low and `tick_enable` is high.
- R2: A write to address 0 stores `bus_wdata[6:0]` as the index and ignores bit 7. A write to address 1 stores the byte at the index, except at 0x0C and 0x0D. A read at address 1 returns that byte on `bus_rdata` one cycle after the strobe.
- R3: Index 0x0A bit 7 is the update-in-progress bit. The `upd_begin` strobe sets it and the `upd_end` strobe clears it, but only while set mode is off. Host writes to 0x0A change only bits 6:0 and leave bit 7 unchanged.
- R4: Each `upd_end` taken while set mode is off does two things. It copies `cal_sec`, `cal_min` and `cal_hour` into indices 0x00, 0x02 and 0x04. It sets the update-ended flag, bit 4 of 0x0C.
- R5: When 0x0B bit 4 (update interrupt enable) is 1, the update-ended event also sets bit 7 of 0x0C (the interrupt flag) and drives `irq` high. When that enable is 0, `irq` stays low.
- R6: A read of 0x0C returns its current value. The same read clears the register to 0x00 and drops `irq`.
- R7: The alarm bytes are 0x01 (seconds), 0x03 (minutes) and 0x05 (hours). When all three match at an `upd_end`, bit 5 of 0x0C (the alarm flag) is set. If 0x0B bit 5 (alarm interrupt enable) is also 1, bit 7 is set and `irq` rises. A single field that differs prevents the alarm.
- R8: An alarm byte whose two top bits are both 1 matches any value. Any other alarm byte must equal the time byte exactly, so a byte with pattern 10 in bits 7:6 is not a wildcard.
- R9: Writing 0x0B with bit 7 (set mode) at 1 clears the update-in-progress bit. While set mode is 1, both strobes are ignored: no flag is set, no time byte is copied and bit 7 of 0x0A stays 0.
- R10: Host writes to 0x0C and 0x0D have no effect. 0x0D always reads 0x80.
- R11: `tick_enable` is high exactly when 0x0A bits 6:4 equal 010 and set mode is off.
- R12: A `soft_rst` pulse clears bits 6, 5 and 3 of 0x0B, keeping the other bits. It also clears 0x0C to 0x00 and drops `irq`.
- R13: If a read of 0x0C and an `upd_end` happen in the same cycle, the read returns the old flags and the flags from the new event stay set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| soft_rst | input | 1 | Clears the interrupt enables and the flag register |
| bus_en | input | 1 | Host access strobe, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| upd_begin | input | 1 | Calendar update starting |
| upd_end | input | 1 | Calendar update complete, time inputs valid |
| cal_sec | input | 8 | Current seconds byte |
| cal_min | input | 8 | Current minutes byte |
| cal_hour | input | 8 | Current hours byte |
| tick_enable | output | 1 | Permits the calendar block to advance |
| irq | output | 1 | Level interrupt, high while an enabled flag is pending |

## Verification
Each kind of wrong internal state shows up at the ports within a cycle or one register read. A wrong update-in-progress state appears in bit 7 of the next read of 0x0A. A dropped or spurious flag appears in the next read of 0x0C. A wrong flag can also change `irq` on the edge that follows the `upd_end` strobe. A wrong alarm compare changes bit 5 of 0x0C. A missed set-mode gate shows in the copied time bytes and in `tick_enable`. The checks cover a read that collides with an update, and the boundary where an alarm byte is a wildcard.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;

    localparam int BYTE_W     = 8;
    localparam int IDX_W      = 7;
    localparam int NUM_BYTES  = 1 << IDX_W;
    localparam int NUM_FIELDS = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // Register positions that software and the calendar neighbour depend on
    localparam idx_t IX_SEC      = 7'h00;
    localparam idx_t IX_ALM_SEC  = 7'h01;
    localparam idx_t IX_MIN      = 7'h02;
    localparam idx_t IX_ALM_MIN  = 7'h03;
    localparam idx_t IX_HOUR     = 7'h04;
    localparam idx_t IX_ALM_HOUR = 7'h05;
    localparam idx_t IX_CTL_A    = 7'h0A;
    localparam idx_t IX_CTL_B    = 7'h0B;
    localparam idx_t IX_FLAGS    = 7'h0C;
    localparam idx_t IX_STAT     = 7'h0D;

    localparam byte_t CTL_A_INIT = 8'h26;
    localparam byte_t CTL_B_INIT = 8'h02;
    localparam byte_t STAT_VALUE = 8'h80;

    // Control B bit positions
    localparam int B_SETMODE = 7;
    localparam int B_PER_EN  = 6;
    localparam int B_ALM_EN  = 5;
    localparam int B_UPD_EN  = 4;
    localparam int B_WAVE_EN = 3;

    // Flag register bit positions
    localparam int F_IRQ = 7;
    localparam int F_ALM = 5;
    localparam int F_UPD = 4;

    localparam logic [2:0] DIV_RUNNING = 3'b010;

    localparam byte_t SOFT_CLR_MASK =
        byte_t'((1 << B_PER_EN) | (1 << B_ALM_EN) | (1 << B_WAVE_EN));

    typedef enum logic [1:0] {
        OP_NONE,
        OP_INDEX,
        OP_WRITE,
        OP_READ
    } host_op_e;

    typedef struct packed {
        byte_t hour;
        byte_t min;
        byte_t sec;
    } time_bytes_t;

    function automatic logic is_wildcard(byte_t b);
        return b[BYTE_W-1:BYTE_W-2] == 2'b11;
    endfunction

    function automatic logic is_ctrl(idx_t ix);
        return (ix == IX_CTL_A) || (ix == IX_CTL_B) ||
               (ix == IX_FLAGS) || (ix == IX_STAT);
    endfunction

    function automatic idx_t time_index(int f);
        case (f)
            0:       return IX_SEC;
            1:       return IX_MIN;
            default: return IX_HOUR;
        endcase
    endfunction

    function automatic idx_t alarm_index(int f);
        case (f)
            0:       return IX_ALM_SEC;
            1:       return IX_ALM_MIN;
            default: return IX_ALM_HOUR;
        endcase
    endfunction

endpackage

// File: rtl/rtc_host_port.sv
module rtc_host_port
    import rtc_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_en,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  idx_t       idx_wdata,
    input  byte_t      rd_value,
    output idx_t       idx_o,
    output host_op_e   op_o,
    output byte_t      rdata_o
);

    idx_t  idx_q;
    byte_t rdata_q;

    always_comb begin
        op_o = OP_NONE;
        if (bus_en) begin
            if (!bus_addr)
                op_o = bus_wr ? OP_INDEX : OP_NONE;
            else
                op_o = bus_wr ? OP_WRITE : OP_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (op_o == OP_INDEX)
                idx_q <= idx_wdata;
            if (op_o == OP_READ)
                rdata_q <= rd_value;
            else if (bus_en && !bus_wr && !bus_addr)
                rdata_q <= '1;
        end
    end

    assign idx_o   = idx_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
    import rtc_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  idx_t        host_idx,
    input  byte_t       host_wdata,
    input  logic        cap_we,
    input  time_bytes_t cap_time,
    output byte_t       rd_data,
    output time_bytes_t alarm_o
);

    byte_t mem_q [NUM_BYTES];
    byte_t cap_arr [NUM_FIELDS];

    assign cap_arr[0] = cap_time.sec;
    assign cap_arr[1] = cap_time.min;
    assign cap_arr[2] = cap_time.hour;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BYTES; i++)
                mem_q[i] <= '0;
        end else begin
            if (host_we)
                mem_q[host_idx] <= host_wdata;
            // capture wins over a same-cycle host write to a time byte
            if (cap_we)
                for (int f = 0; f < NUM_FIELDS; f++)
                    mem_q[time_index(f)] <= cap_arr[f];
        end
    end

    assign rd_data      = mem_q[host_idx];
    assign alarm_o.sec  = mem_q[alarm_index(0)];
    assign alarm_o.min  = mem_q[alarm_index(1)];
    assign alarm_o.hour = mem_q[alarm_index(2)];

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_regs_pkg::*;
(
    input  time_bytes_t alarm,
    input  time_bytes_t now,
    output logic        hit
);

    logic [NUM_FIELDS-1:0] field_ok;

    generate
        for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
            byte_t a_b;
            byte_t n_b;
            assign a_b = alarm[f*BYTE_W +: BYTE_W];
            assign n_b = now[f*BYTE_W +: BYTE_W];
            assign field_ok[f] = is_wildcard(a_b) || (a_b == n_b);
        end
    endgenerate

    assign hit = &field_ok;

endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
    import rtc_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  soft_clr,
    input  logic  rd_clr,
    input  logic  set_alm,
    input  logic  set_upd,
    input  logic  alm_irq_en,
    input  logic  upd_irq_en,
    output byte_t flags_o,
    output logic  irq_o
);

    logic irqf_q, alm_q, upd_q;
    logic raise;

    assign raise = (set_alm && alm_irq_en) || (set_upd && upd_irq_en);

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            irqf_q <= 1'b0;
            alm_q  <= 1'b0;
            upd_q  <= 1'b0;
        end else begin
            // read-clear first, then the new events of this cycle are kept
            irqf_q <= (irqf_q && !rd_clr) || raise;
            alm_q  <= (alm_q  && !rd_clr) || set_alm;
            upd_q  <= (upd_q  && !rd_clr) || set_upd;
        end
    end

    always_comb begin
        flags_o        = '0;
        flags_o[F_IRQ] = irqf_q;
        flags_o[F_ALM] = alm_q;
        flags_o[F_UPD] = upd_q;
    end

    assign irq_o = irqf_q;

    AST_FLAGS_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !set_alm && !set_upd) |=> (flags_o == '0)); // R6

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(raise)); // R5

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic       bus_en,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       upd_begin,
    input  logic       upd_end,
    input  logic [7:0] cal_sec,
    input  logic [7:0] cal_min,
    input  logic [7:0] cal_hour,
    output logic       tick_enable,
    output logic       irq
);

    idx_t        idx;
    host_op_e    op;
    byte_t       rd_value;
    byte_t       store_rd;
    byte_t       flags;
    time_bytes_t alarm_bytes;
    time_bytes_t now_bytes;
    logic        alarm_hit;

    logic [BYTE_W-2:0] ctl_a_q;
    logic              uip_q;
    byte_t             ctl_b_q;

    logic set_mode, host_wr, wr_a, wr_b, store_we, rd_clr;
    logic upd_go, upd_fire;

    assign now_bytes.sec  = cal_sec;
    assign now_bytes.min  = cal_min;
    assign now_bytes.hour = cal_hour;

    assign set_mode = ctl_b_q[B_SETMODE];
    assign host_wr  = (op == OP_WRITE);
    assign wr_a     = host_wr && (idx == IX_CTL_A);
    assign wr_b     = host_wr && (idx == IX_CTL_B);
    assign store_we = host_wr && !is_ctrl(idx);
    assign rd_clr   = (op == OP_READ) && (idx == IX_FLAGS);
    assign upd_go   = upd_begin && !set_mode;
    assign upd_fire = upd_end && !set_mode;

    rtc_host_port i_host_port (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .idx_wdata (bus_wdata[IDX_W-1:0]),
        .rd_value  (rd_value),
        .idx_o     (idx),
        .op_o      (op),
        .rdata_o   (bus_rdata)
    );

    rtc_byte_store i_store (
        .clk        (clk),
        .rst        (rst),
        .host_we    (store_we),
        .host_idx   (idx),
        .host_wdata (bus_wdata),
        .cap_we     (upd_fire),
        .cap_time   (now_bytes),
        .rd_data    (store_rd),
        .alarm_o    (alarm_bytes)
    );

    rtc_alarm_match i_alarm (
        .alarm (alarm_bytes),
        .now   (now_bytes),
        .hit   (alarm_hit)
    );

    rtc_flag_unit i_flags (
        .clk        (clk),
        .rst        (rst),
        .soft_clr   (soft_rst),
        .rd_clr     (rd_clr),
        .set_alm    (upd_fire && alarm_hit),
        .set_upd    (upd_fire),
        .alm_irq_en (ctl_b_q[B_ALM_EN]),
        .upd_irq_en (ctl_b_q[B_UPD_EN]),
        .flags_o    (flags),
        .irq_o      (irq)
    );

    // Control A: bit 7 is hardware-owned
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_a_q <= CTL_A_INIT[BYTE_W-2:0];
            uip_q   <= 1'b0;
        end else begin
            if (wr_a)
                ctl_a_q <= bus_wdata[BYTE_W-2:0];
            if (wr_b && bus_wdata[B_SETMODE])
                uip_q <= 1'b0;
            else if (upd_fire)
                uip_q <= 1'b0;
            else if (upd_go)
                uip_q <= 1'b1;
        end
    end

    // Control B
    always_ff @(posedge clk) begin
        if (rst)
            ctl_b_q <= CTL_B_INIT;
        else if (soft_rst)
            ctl_b_q <= (wr_b ? bus_wdata : ctl_b_q) & ~SOFT_CLR_MASK;
        else if (wr_b)
            ctl_b_q <= bus_wdata;
    end

    always_comb begin
        case (idx)
            IX_CTL_A: rd_value = {uip_q, ctl_a_q};
            IX_CTL_B: rd_value = ctl_b_q;
            IX_FLAGS: rd_value = flags;
            IX_STAT:  rd_value = STAT_VALUE;
            default:  rd_value = store_rd;
        endcase
    end

    assign tick_enable = (ctl_a_q[6:4] == DIV_RUNNING) && !set_mode;

    AST_UIP_HOST_READONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_a && !upd_begin && !upd_end) |=> (uip_q == $past(uip_q))); // R3

    AST_SET_NO_UIP: assert property (@(posedge clk) disable iff (rst)
        set_mode |-> !uip_q); // R9

    AST_UF_AT_END: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && !soft_rst) |=> flags[F_UPD]); // R4

    AST_ALARM_IRQ: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && alarm_hit && ctl_b_q[B_ALM_EN] && !soft_rst) |=> irq); // R7

endmodule

// File: tb/test_rtc_regfile.sv
module test_rtc_regfile;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       upd_begin = 1'b0;
    logic       upd_end = 1'b0;
    logic [7:0] cal_sec = '0;
    logic [7:0] cal_min = '0;
    logic [7:0] cal_hour = '0;
    logic       tick_enable;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rtc_regfile i_rtc_regfile (
        .clk (clk), .rst (rst), .soft_rst (soft_rst),
        .bus_en (bus_en), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .upd_begin (upd_begin), .upd_end (upd_end),
        .cal_sec (cal_sec), .cal_min (cal_min), .cal_hour (cal_hour),
        .tick_enable (tick_enable), .irq (irq)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic bus_cycle(input logic wr, input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
        bus_cycle(1'b1, 1'b0, ix);
        bus_cycle(1'b1, 1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] ix, output logic [7:0] d);
        bus_cycle(1'b1, 1'b0, ix);
        bus_cycle(1'b0, 1'b1, 8'h00);
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] ix, input logic [7:0] exp);
        logic [7:0] v;
        reg_rd(ix, v);
        chk(tag, v, exp);
    endtask

    task automatic pulse_begin();
        @(negedge clk); upd_begin = 1'b1;
        @(negedge clk); upd_begin = 1'b0;
    endtask

    task automatic pulse_end(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
        @(negedge clk);
        cal_sec = s; cal_min = m; cal_hour = h; upd_end = 1'b1;
        @(negedge clk); upd_end = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 tick_enable", {7'd0, tick_enable}, 8'h01);
        rd_chk("R1 ctl A", 8'h0A, 8'h26);
        rd_chk("R1 ctl B", 8'h0B, 8'h02);
        rd_chk("R1 flags", 8'h0C, 8'h00);
        rd_chk("R1 status", 8'h0D, 8'h80);
        rd_chk("R1 storage", 8'h40, 8'h00);
    endtask

    task automatic t_storage();
        reg_wr(8'h20, 8'h5A);
        reg_wr(8'h7F, 8'hA5);
        rd_chk("R2 byte 0x20", 8'h20, 8'h5A);
        rd_chk("R2 byte 0x7F", 8'h7F, 8'hA5);
        reg_wr(8'hE0, 8'h3C);          // bit 7 of index ignored -> 0x60
        rd_chk("R2 index bit7 dropped", 8'h60, 8'h3C);
    endtask

    task automatic t_update_basic();
        pulse_begin();
        rd_chk("R3 UIP set on begin", 8'h0A, 8'hA6);
        reg_wr(8'h0A, 8'h20);
        rd_chk("R3 UIP kept on host write", 8'h0A, 8'hA0);
        pulse_end(8'h59, 8'h30, 8'h12);
        chk("R5 no irq with UIE off", {7'd0, irq}, 8'h00);
        rd_chk("R3 UIP cleared at end", 8'h0A, 8'h20);
        rd_chk("R4 seconds copied", 8'h00, 8'h59);
        rd_chk("R4 minutes copied", 8'h02, 8'h30);
        rd_chk("R4 hours copied", 8'h04, 8'h12);
        rd_chk("R4 UF set", 8'h0C, 8'h10);
        rd_chk("R6 flags cleared", 8'h0C, 8'h00);
    endtask

    task automatic t_uie();
        reg_wr(8'h0B, 8'h12);
        pulse_begin();
        pulse_end(8'h10, 8'h20, 8'h05);
        chk("R5 irq high", {7'd0, irq}, 8'h01);
        rd_chk("R5 flags IRQF|UF", 8'h0C, 8'h90);
        chk("R6 irq dropped", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_alarm();
        reg_wr(8'h0B, 8'h22);
        reg_wr(8'h01, 8'h45);
        reg_wr(8'h03, 8'h20);
        reg_wr(8'h05, 8'h05);
        pulse_begin();
        pulse_end(8'h45, 8'h20, 8'h05);
        chk("R7 irq on alarm", {7'd0, irq}, 8'h01);
        rd_chk("R7 flags IRQF|AF|UF", 8'h0C, 8'hB0);
        pulse_begin();
        pulse_end(8'h46, 8'h20, 8'h05);
        chk("R7 no irq on mismatch", {7'd0, irq}, 8'h00);
        rd_chk("R7 flags UF only", 8'h0C, 8'h10);
    endtask

    task automatic t_wild();
        reg_wr(8'h01, 8'hC3);
        reg_wr(8'h03, 8'hFF);
        pulse_begin();
        pulse_end(8'h07, 8'h33, 8'h05);
        rd_chk("R8 wildcards match", 8'h0C, 8'hB0);
        reg_wr(8'h05, 8'h85);          // bits 7:6 = 10: not a wildcard
        pulse_begin();
        pulse_end(8'h07, 8'h33, 8'h05);
        rd_chk("R8 pattern 10 not wild", 8'h0C, 8'h10);
    endtask

    task automatic t_set();
        reg_wr(8'h0B, 8'h02);
        pulse_begin();
        reg_wr(8'h0B, 8'h82);
        rd_chk("R9 SET clears UIP", 8'h0A, 8'h20);
        chk("R11 tick off in set mode", {7'd0, tick_enable}, 8'h00);
        pulse_begin();
        rd_chk("R9 UIP stays clear", 8'h0A, 8'h20);
        pulse_end(8'h11, 8'h22, 8'h13);
        rd_chk("R9 no flags in set mode", 8'h0C, 8'h00);
        rd_chk("R9 time not copied", 8'h00, 8'h07);
        reg_wr(8'h0B, 8'h02);
        chk("R11 tick back on", {7'd0, tick_enable}, 8'h01);
    endtask

    task automatic t_readonly();
        reg_wr(8'h0C, 8'hFF);
        reg_wr(8'h0D, 8'h00);
        chk("R10 irq unaffected", {7'd0, irq}, 8'h00);
        rd_chk("R10 flags unwritable", 8'h0C, 8'h00);
        rd_chk("R10 status fixed", 8'h0D, 8'h80);
    endtask

    task automatic t_divider();
        reg_wr(8'h0A, 8'h46);
        chk("R11 divider stopped", {7'd0, tick_enable}, 8'h00);
        reg_wr(8'h0A, 8'h26);
        chk("R11 divider running", {7'd0, tick_enable}, 8'h01);
    endtask

    task automatic t_soft();
        reg_wr(8'h0B, 8'h7A);
        pulse_begin();
        pulse_end(8'h01, 8'h01, 8'h01);
        chk("R12 pending before soft reset", {7'd0, irq}, 8'h01);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk("R12 irq dropped", {7'd0, irq}, 8'h00);
        rd_chk("R12 enables cleared", 8'h0B, 8'h12);
        rd_chk("R12 flags cleared", 8'h0C, 8'h00);
    endtask

    task automatic t_collide();
        bus_cycle(1'b1, 1'b0, 8'h0C);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1;
        cal_sec = 8'h02; cal_min = 8'h02; cal_hour = 8'h02; upd_end = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; upd_end = 1'b0;
        chk("R13 read sees old flags", bus_rdata, 8'h00);
        chk("R13 irq from new event", {7'd0, irq}, 8'h01);
        rd_chk("R13 new flags kept", 8'h0C, 8'h90);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_storage();
        t_update_basic();
        t_uie();
        t_alarm();
        t_wild();
        t_set();
        t_readonly();
        t_divider();
        t_soft();
        t_collide();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule